// File: doc/BRIEF.md
# Driver Overload and Reset Supervisor

This block watches over a bank of low-side driver channels. For each channel it runs an overload timer. The timer starts when that channel's current-limit flag is raised while the channel is driving. If the limit is still present when the timer runs out, the block sends a one-cycle clear to that channel's command latch. The channel then switches itself off. It can be turned on again by writing the command once more, and a short that is still present simply repeats the limit-and-clear cycle.

An overtemperature flag masks every driver enable for as long as it is raised, without touching the stored commands. When the flag drops, the drivers again follow whatever the latches hold. Those are the old commands if nothing was written during the shutdown, or the newer ones if something was.

The block also qualifies the external active-low reset pin by pulse width. It merges the qualified reset with the power-on reset into one internal reset, and that reset clears every latch and timer. The block is clocked by the internal oscillator. In the first test mode it shortens the timer prescaler and produces the oscillator divided by two for the serial output path. The second test-mode flag is passed through unchanged.

Top module: `prot_timing_ctrl`

## Requirements
- R1: While `por_i` is high, `int_rst_o` is high and every bit of `latch_clr_o` is high; on leaving reset the oscillator-divided output is 0.
- R2: After a two-stage synchronizer, `ext_rst_n_i` must be low for at least RST_MIN consecutive clock samples before `int_rst_o` rises. A shorter low pulse has no effect on `int_rst_o` or `latch_clr_o`.
- R3: `drv_en_o` bit i is 1 only when `latch_q_i` bit i is 1 and `overtemp_i` is 0. When `overtemp_i` falls, `drv_en_o` equals the latch contents present at that time: the old ones if nothing was written, the new ones otherwise.
- R4: A channel is armed when its `ovc_i` bit is 1 and its `drv_en_o` bit is 1. Counting from the first clock edge at which it is armed, and with the channel held armed, `latch_clr_o` for that channel pulses high for exactly one cycle. The pulse is visible after edge N, where (TMR_TICKS-1)*D+1 <= N <= TMR_TICKS*D and D is the active prescaler ratio.
- R5: If the channel stops being armed before expiry, its timer returns to zero, so re-arming again takes the full R4 window.
- R6: An expiry clears only the channel that expired; the `latch_clr_o` bits of the other channels stay 0.
- R7: No clear is issued for a channel whose driver is disabled, whether its latch is 0 or `overtemp_i` is high, however long its `ovc_i` stays 1.
- R8: With `test1_i` high, the prescaler ratio D is PRE_DIV_TEST instead of PRE_DIV.
- R9: With `test1_i` high, `tm_clk_o` toggles on every clock edge; with `test1_i` low it is 0.
- R10: `tm2_o` equals `test2_i`.
- R11: After an expiry clear, writing the latch to 1 again re-arms the channel. A short that is still present then gives another clear within the R4 window.
- R12: A qualified external reset that arrives while an overload count is running clears all channels. The next arming starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| por_i | input | 1 | Power-on reset flag, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, unfiltered |
| ovc_i | input | NCH | Per-channel current-limit flag |
| overtemp_i | input | 1 | Overtemperature flag (hysteresis already applied) |
| test1_i | input | 1 | First test mode: short prescaler and divided clock out |
| test2_i | input | 1 | Second test mode flag |
| latch_q_i | input | NCH | Command latch contents, 1 = channel on |
| drv_en_o | output | NCH | Driver enables after thermal masking |
| latch_clr_o | output | NCH | Per-channel command latch clear |
| int_rst_o | output | 1 | Combined internal reset |
| tm_clk_o | output | 1 | Oscillator divided by two in test mode, else 0 |
| tm2_o | output | 1 | Second test mode status |

## Verification
Two functions can act in the same cycle. A running overload count and the external reset both drive `latch_clr_o`, and an overtemperature mask can cut into an overload count. The bench starts a short on one channel and, partway through the count, either holds the reset pin low for longer than the qualifying width or raises the overtemperature flag with every channel shorted. It judges the result at the ports. After the reset, all latches must be clear and a fresh arming must again take the full window. Under the mask, no clear may appear at all, and the stored commands must come back intact.

// File: rtl/prot_pkg.sv
package prot_pkg;

  // Last count value of the prescaler for the selected ratio.
  function automatic int prescale_last(input logic fast, input int div_norm,
                                       input int div_test);
    return (fast ? div_test : div_norm) - 1;
  endfunction

  // Earliest and latest edge (counted from arming) of an expiry pulse.
  function automatic int window_lo(input int ticks, input int div);
    return (ticks - 1) * div + 1;
  endfunction

  function automatic int window_hi(input int ticks, input int div);
    return ticks * div;
  endfunction

endpackage

// File: rtl/prot_prescaler.sv
module prot_prescaler #(
  parameter int DIV_NORM = 256,
  parameter int DIV_TEST = 4,
  parameter int W        = 8
) (
  input  logic clk,
  input  logic rst_a,
  input  logic rst_s,
  input  logic fast_i,
  output logic tick_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  always_comb begin
    last   = W'(prot_pkg::prescale_last(fast_i, DIV_NORM, DIV_TEST));
    tick_o = (cnt >= last);
  end

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a)        cnt <= '0;
    else if (rst_s)   cnt <= '0;
    else if (tick_o)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prot_ovl_timer.sv
module prot_ovl_timer #(
  parameter int TICKS = 145,
  parameter int W     = 8
) (
  input  logic clk,
  input  logic rst_a,
  input  logic rst_s,
  input  logic arm_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == W'(TICKS - 1));

  always_ff @(posedge clk or posedge rst_a) begin
    if (rst_a) begin
      cnt      <= '0;
      expire_o <= 1'b0;
    end else if (rst_s) begin
      cnt      <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= arm_i & tick_i & at_end;
      if (!arm_i)       cnt <= '0;
      else if (tick_i)  cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/prot_rst_filter.sv
module prot_rst_filter #(
  parameter int MIN = 160,
  parameter int W   = 8
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  output logic pin_low_o,
  output logic hold_o
);
  logic         s1, s2;
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      low_cnt <= '0;
    end else begin
      s1 <= pin_n_i;
      s2 <= s1;
      if (s2)                        low_cnt <= '0;
      else if (low_cnt != W'(MIN))   low_cnt <= low_cnt + 1'b1;
    end
  end

  assign pin_low_o = ~s2;
  assign hold_o    = (low_cnt == W'(MIN));
endmodule

// File: rtl/prot_timing_ctrl.sv
module prot_timing_ctrl #(
  parameter int NCH          = 8,
  parameter int PRE_DIV      = 256,
  parameter int PRE_DIV_TEST = 4,
  parameter int TMR_TICKS    = 145,
  parameter int RST_MIN      = 160
) (
  input  logic           clk,
  input  logic           por_i,
  input  logic           ext_rst_n_i,
  input  logic [NCH-1:0] ovc_i,
  input  logic           overtemp_i,
  input  logic           test1_i,
  input  logic           test2_i,
  input  logic [NCH-1:0] latch_q_i,
  output logic [NCH-1:0] drv_en_o,
  output logic [NCH-1:0] latch_clr_o,
  output logic           int_rst_o,
  output logic           tm_clk_o,
  output logic           tm2_o
);
  localparam int PRE_MAX = (PRE_DIV > PRE_DIV_TEST) ? PRE_DIV : PRE_DIV_TEST;
  localparam int PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam int TMR_W   = (TMR_TICKS > 2) ? $clog2(TMR_TICKS) : 1;
  localparam int RST_W   = $clog2(RST_MIN + 1);

  // Named internal events, observed by the bound checker.
  logic           tick_w;
  logic           ext_hold_w;
  logic           pin_low_w;
  logic [NCH-1:0] arm_w;
  logic [NCH-1:0] expire_w;
  logic           div2_q;

  prot_rst_filter #(.MIN(RST_MIN), .W(RST_W)) u_rst (
    .clk      (clk),
    .por_i    (por_i),
    .pin_n_i  (ext_rst_n_i),
    .pin_low_o(pin_low_w),
    .hold_o   (ext_hold_w)
  );

  assign int_rst_o = por_i | ext_hold_w;

  prot_prescaler #(.DIV_NORM(PRE_DIV), .DIV_TEST(PRE_DIV_TEST), .W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_a (por_i),
    .rst_s (ext_hold_w),
    .fast_i(test1_i),
    .tick_o(tick_w)
  );

  // Thermal mask leaves the latches untouched.
  assign drv_en_o = latch_q_i & {NCH{~overtemp_i}};
  assign arm_w    = ovc_i & drv_en_o;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    prot_ovl_timer #(.TICKS(TMR_TICKS), .W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_a   (por_i),
      .rst_s   (ext_hold_w),
      .arm_i   (arm_w[ch]),
      .tick_i  (tick_w),
      .expire_o(expire_w[ch])
    );
  end

  assign latch_clr_o = expire_w | {NCH{int_rst_o}};

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) div2_q <= 1'b0;
    else       div2_q <= ~div2_q;
  end

  assign tm_clk_o = test1_i & div2_q;
  assign tm2_o    = test2_i;
endmodule

// File: rtl/prot_timing_ctrl_chk.sv
module prot_timing_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           por_i,
  input logic           int_rst_o,
  input logic [NCH-1:0] ovc_i,
  input logic [NCH-1:0] drv_en_o,
  input logic [NCH-1:0] expire_w,
  input logic           tick_w,
  input logic           ext_hold_w,
  input logic           pin_low_w,
  input logic           test1_i,
  input logic           tm_clk_o
);
  assert_clr_needs_arm_R4: assert property (@(posedge clk) disable iff (int_rst_o)
    (|expire_w) |-> ((expire_w & ~$past(ovc_i & drv_en_o)) == '0));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (int_rst_o)
    (|expire_w) |=> ((expire_w & $past(expire_w)) == '0));

  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (int_rst_o)
    tick_w |=> !tick_w);

  assert_hold_needs_low_R2: assert property (@(posedge clk) disable iff (por_i)
    ext_hold_w |-> $past(pin_low_w));

  assert_tm_toggle_R9: assert property (@(posedge clk) disable iff (por_i)
    (test1_i && $past(test1_i)) |-> (tm_clk_o != $past(tm_clk_o)));
endmodule

bind prot_timing_ctrl prot_timing_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .por_i     (por_i),
  .int_rst_o (int_rst_o),
  .ovc_i     (ovc_i),
  .drv_en_o  (drv_en_o),
  .expire_w  (expire_w),
  .tick_w    (tick_w),
  .ext_hold_w(ext_hold_w),
  .pin_low_w (pin_low_w),
  .test1_i   (test1_i),
  .tm_clk_o  (tm_clk_o)
);

// File: tb/prot_timing_ctrl_test.sv
module prot_timing_ctrl_test;
  localparam int NCH  = 4;
  localparam int DIVN = 16;
  localparam int DIVT = 2;
  localparam int TK   = 5;
  localparam int RMIN = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           por, pin_n, ot, t1, t2, wr_req;
  logic [NCH-1:0] ovc, lat, wr_val, drv, clr, clr_q;
  logic           irst, tmc, tm2;
  int checks = 0;
  int errors = 0;

  prot_timing_ctrl #(.NCH(NCH), .PRE_DIV(DIVN), .PRE_DIV_TEST(DIVT),
                     .TMR_TICKS(TK), .RST_MIN(RMIN)) uut (
    .clk(clk), .por_i(por), .ext_rst_n_i(pin_n), .ovc_i(ovc), .overtemp_i(ot),
    .test1_i(t1), .test2_i(t2), .latch_q_i(lat), .drv_en_o(drv),
    .latch_clr_o(clr), .int_rst_o(irst), .tm_clk_o(tmc), .tm2_o(tm2));

  // Command latch model: written by the bench, cleared by the block.
  always @(negedge clk) clr_q <= clr;
  always @(posedge clk) lat <= (wr_req ? wr_val : lat) & ~clr_q;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic [NCH-1:0] v);
    wr_req = 1'b1;
    wr_val = v;
    step();
    wr_req = 1'b0;
  endtask

  task automatic wait_clr(input int ch, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!clr[ch] && n < 2000);
  endtask

  task automatic chk_window(input int n, input int div, input string req);
    int lo, hi;
    lo = (TK - 1) * div + 1;
    hi = TK * div;
    chk(n >= lo && n <= hi, req, n, lo);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [NCH-1:0] acc;
    logic seen;
    por = 1'b1; pin_n = 1'b1; ot = 1'b0; t1 = 1'b0; t2 = 1'b0;
    ovc = '0; wr_req = 1'b0; wr_val = '0; lat = '0;
    repeat (3) step();
    // R1: reset state
    chk(irst == 1'b1, "R1 int_rst during por", int'(irst), 1);
    chk(clr == '1, "R1 all clears during por", int'(clr), 15);
    por = 1'b0;
    step();
    chk(irst == 1'b0 && tmc == 1'b0, "R1 after por", int'({irst, tmc}), 0);
    chk(lat == '0, "R1 latches cleared", int'(lat), 0);

    // R10
    t2 = 1'b1; step();
    chk(tm2 == 1'b1, "R10 tm2 high", int'(tm2), 1);
    t2 = 1'b0; step();
    chk(tm2 == 1'b0, "R10 tm2 low", int'(tm2), 0);

    // R2: pulse-width sweep of the external reset
    for (int len = 1; len <= RMIN + 2; len++) begin
      seen = 1'b0;
      pin_n = 1'b0;
      for (int k = 0; k < len; k++) begin step(); seen |= irst; end
      pin_n = 1'b1;
      for (int k = 0; k < 6; k++) begin step(); seen |= irst; end
      chk(seen == (len >= RMIN), $sformatf("R2 pulse len %0d", len),
          int'(seen), int'(len >= RMIN));
    end

    // R4/R6: normal ratio, each channel, others untouched
    for (int ch = 0; ch < NCH; ch++) begin
      do_write('1);
      ovc = '0; ovc[ch] = 1'b1;
      wait_clr(ch, n);
      chk_window(n, DIVN, $sformatf("R4 expiry ch%0d", ch));
      acc = '0; acc[ch] = 1'b1;
      chk(clr == acc, "R6 only the expired channel clears", int'(clr), int'(acc));
      ovc = '0;
      step();
      chk(clr[ch] == 1'b0, "R4 single-cycle pulse", int'(clr[ch]), 0);
      chk(lat == ~acc, "R6 other latches kept", int'(lat), int'(~acc));
    end

    // R11: persisting short, re-arm by rewriting
    do_write(4'b0001);
    ovc = 4'b0001;
    wait_clr(0, n);
    chk_window(n, DIVN, "R11 first limit cycle");
    step();
    chk(lat[0] == 1'b0 && drv[0] == 1'b0, "R11 channel off", int'(drv[0]), 0);
    do_write(4'b0001);
    wait_clr(0, n);
    chk_window(n, DIVN, "R11 repeat limit cycle");
    ovc = '0; step();

    // R7: latch off, long overload, no clear
    do_write('0);
    ovc = '1; acc = '0;
    for (int k = 0; k < 3 * TK * DIVN; k++) begin step(); acc |= clr; end
    chk(acc == '0, "R7 no clear while latch off", int'(acc), 0);
    ovc = '0;

    // R3/R7: thermal mask with running overloads
    do_write('1);
    ot = 1'b1; step();
    chk(drv == '0, "R3 drivers masked", int'(drv), 0);
    ovc = '1; acc = '0;
    for (int k = 0; k < 3 * TK * DIVN; k++) begin step(); acc |= clr; end
    chk(acc == '0, "R7 no clear under overtemp", int'(acc), 0);
    ovc = '0;
    ot = 1'b0; step();
    chk(drv == '1, "R3 old commands restored", int'(drv), 15);
    ot = 1'b1;
    do_write(4'b0101);
    ot = 1'b0; step();
    chk(drv == 4'b0101, "R3 new commands after overtemp", int'(drv), 5);

    // R12: qualified reset during a running count
    do_write('1);
    ovc = 4'b0010;
    repeat (20) step();
    pin_n = 1'b0; seen = 1'b0; acc = '0;
    for (int k = 0; k < RMIN + 3; k++) begin
      step(); seen |= irst; if (irst) acc |= clr;
    end
    pin_n = 1'b1; ovc = '0;
    repeat (6) step();
    chk(seen && acc == '1, "R12 reset clears all channels", int'(acc), 15);
    chk(lat == '0, "R12 latches empty after reset", int'(lat), 0);
    do_write(4'b0010);
    ovc = 4'b0010;
    wait_clr(1, n);
    chk_window(n, DIVN, "R12 full window after reset");
    ovc = '0; step();

    // R9/R8: test mode
    t1 = 1'b1; step();
    for (int k = 0; k < 8; k++) begin
      logic prev;
      prev = tmc;
      step();
      chk(tmc != prev, "R9 divided clock toggles", int'(tmc), int'(~prev));
    end
    for (int ch = 0; ch < NCH; ch++) begin
      do_write('1);
      ovc = '0; ovc[ch] = 1'b1;
      wait_clr(ch, n);
      chk_window(n, DIVT, $sformatf("R8 short ratio ch%0d", ch));
      ovc = '0; step();
    end

    // R5: drop before expiry, then a full window again
    do_write(4'b1000);
    ovc = 4'b1000; acc = '0;
    for (int k = 0; k < (TK - 1) * DIVT - 1; k++) begin step(); acc |= clr; end
    ovc = '0; step(); acc |= clr;
    chk(acc == '0, "R5 no clear on early drop", int'(acc), 0);
    ovc = 4'b1000;
    wait_clr(3, n);
    chk_window(n, DIVT, "R5 timer restarted from zero");
    ovc = '0;
    t1 = 1'b0;
    repeat (2) step();
    chk(tmc == 1'b0, "R9 divided clock off", int'(tmc), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule